// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Alarm

This block keeps wall-clock time from a one-pulse-per-second tick. Hours, minutes and seconds are held as packed BCD bytes. The date is a plain binary count of days, 15 bits wide by default. Software reaches every field through byte-wide registers on a small request channel. A calendar control register starts and stops counting, enables the alarm comparisons one field at a time, and shows a busy bit while a tick update is being applied.

The alarm watches minute, hour and day, and each of these fields has its own enable. The comparison is made only when seconds roll over to 00. A match sets a sticky flag. Software clears the flag by writing 1 to its bit. The interrupt pin is that flag gated by an interrupt enable.

The request channel uses valid/ready. `req_ready` is held high, so a request is accepted in every cycle in which `req_valid` is high. A requester that holds `req_valid` for several cycles therefore issues one request per cycle. A read returns its byte one cycle after acceptance, with `rsp_valid` high for that single cycle. The response has no back-pressure, so the requester must take the byte in that cycle.

Top module: `rtc_core`

## Requirements
- R1: After reset, all time, alarm and control fields read as 0x00, and `alarm_irq` and `cal_busy` are low.
- R2: An accepted read returns, in the next cycle, the byte of the addressed register with `rsp_valid` high. The register addresses are:
  - 0x14: control
  - 0x15: seconds
  - 0x16: minutes
  - 0x17: hours
  - 0x18: day bits 7:0
  - 0x19: day bits 14:8, in read bits 6:0 with bit 7 reading 0
  - 0x1A: alarm minute
  - 0x1B: alarm hour
  - 0x1C: alarm day low byte
  - 0x1D: alarm day high byte
- R3: Seconds count in BCD from 0x00 to 0x59. A tick at 0x59 gives 0x00 and carries into minutes.
- R4: Minutes count in BCD from 0x00 to 0x59. On a carry, minutes at 0x59 go to 0x00 and carry into hours.
- R5: Hours count in BCD from 0x00 to 0x23. On a carry, hours at 0x23 go to 0x00 and increment the day count.
- R6: The day count is a 15-bit binary value that wraps from 0x7FFF to 0x0000.
- R7: A tick advances the time only while control bit 0 (run) is 1. Otherwise the tick has no effect.
- R8: A tick accepted while running raises `cal_busy` and control bit 7 for exactly the following cycle. The counters take their new values at the end of that cycle. Bit 7 is read-only.
- R9: A write to any time register (0x15 to 0x19) that is accepted while busy is dropped. The same write made outside busy takes effect.
- R10: When a tick brings seconds to 0x00, the alarm flag (control bit 2) is set if every enabled field equals the new count. The enables are bit 3 for minute, bit 4 for hour and bit 5 for day. A disabled field is not compared.
- R11: With bits 5:3 all 0, the alarm flag never sets. The flag is also not set on a tick that leaves seconds at a value other than 0x00.
- R12: Writing control with bit 2 at 1 clears the flag. Writing it with bit 2 at 0 leaves the flag unchanged.
- R13: `alarm_irq` is high exactly when the flag is set and control bit 1 (interrupt enable) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Always high; request accepted when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Register byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 8 | Read data byte |
| cal_busy | output | 1 | Tick update in progress |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
The assertions assume that software writes only legal BCD values into the time and alarm fields. They also assume that tick pulses are one cycle wide and are separated by idle cycles. The range and roll-over properties rely on both assumptions. The stimulus writes only valid BCD bytes and issues every tick as a single-cycle pulse followed by at least one quiet cycle. Requests are driven between clock edges and held for exactly one cycle.

// File: rtl/rtc_core_pkg.sv
package rtc_core_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] ADDR_CTL   = 8'h14;
  localparam logic [BYTE_W-1:0] ADDR_SEC   = 8'h15;
  localparam logic [BYTE_W-1:0] ADDR_MIN   = 8'h16;
  localparam logic [BYTE_W-1:0] ADDR_HOUR  = 8'h17;
  localparam logic [BYTE_W-1:0] ADDR_DAYL  = 8'h18;
  localparam logic [BYTE_W-1:0] ADDR_DAYH  = 8'h19;
  localparam logic [BYTE_W-1:0] ADDR_AMIN  = 8'h1A;
  localparam logic [BYTE_W-1:0] ADDR_AHOUR = 8'h1B;
  localparam logic [BYTE_W-1:0] ADDR_ADAYL = 8'h1C;
  localparam logic [BYTE_W-1:0] ADDR_ADAYH = 8'h1D;

  localparam int CB_BUSY  = 7;
  localparam int CB_DAYEN = 5;
  localparam int CB_HREN  = 4;
  localparam int CB_MINEN = 3;
  localparam int CB_FLAG  = 2;
  localparam int CB_IEN   = 1;
  localparam int CB_RUN   = 0;

  typedef struct packed {
    logic day_en;
    logic hour_en;
    logic min_en;
  } match_en_t;
endpackage

// File: rtl/rtc_bcd_counter.sv
module rtc_bcd_counter #(
  parameter int TENS_W = 3,
  parameter logic [TENS_W+3:0] MAX_BCD = 'h59
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              load,
  input  logic [TENS_W+3:0] load_val,
  output logic [TENS_W+3:0] value,
  output logic [TENS_W+3:0] nxt,
  output logic              at_max
);
  localparam int W = TENS_W + 4;

  logic [W-1:0] inc_val;

  always_comb begin
    if (value == MAX_BCD)
      inc_val = '0;
    else if (value[3:0] == 4'd9)
      inc_val = {TENS_W'(value[W-1:4] + 1'b1), 4'd0};
    else
      inc_val = {value[W-1:4], value[3:0] + 4'd1};
  end

  assign at_max = (value == MAX_BCD);
  assign nxt    = step ? inc_val : value;

  always_ff @(posedge clk) begin
    if (!rst_n)    value <= '0;
    else if (load) value <= load_val;
    else if (step) value <= inc_val;
  end

  // R3, R4, R5: digits stay legal BCD and within the counter limit
  a_r3_bcd_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (value[3:0] <= 4'd9) && (value <= MAX_BCD));

  // R3, R4, R5: a step at the limit returns the field to zero
  a_r3_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && value == MAX_BCD) |=> (value == '0));
endmodule

// File: rtl/rtc_day_counter.sv
module rtc_day_counter #(
  parameter int DAY_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             ld_lo,
  input  logic             ld_hi,
  input  logic [7:0]       wbyte,
  output logic [DAY_W-1:0] value,
  output logic [DAY_W-1:0] nxt
);
  localparam int HI_W = DAY_W - 8;

  assign nxt = step ? value + 1'b1 : value;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value <= '0;
    end else if (ld_lo || ld_hi) begin
      if (ld_lo) value[7:0]       <= wbyte;
      if (ld_hi) value[DAY_W-1:8] <= wbyte[HI_W-1:0];
    end else if (step) begin
      value <= value + 1'b1;
    end
  end

  // R6: the binary day count wraps from all ones to zero
  a_r6_day_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld_lo && !ld_hi && (&value)) |=> (value == '0));
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_core_pkg::*;
#(
  parameter int DAY_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_amin,
  input  logic             wr_ahour,
  input  logic             wr_adayl,
  input  logic             wr_adayh,
  input  logic [7:0]       wbyte,
  input  match_en_t        en,
  input  logic             eval,
  input  logic [6:0]       new_sec,
  input  logic [6:0]       new_min,
  input  logic [5:0]       new_hour,
  input  logic [DAY_W-1:0] new_day,
  input  logic             clr,
  output logic             flag,
  output logic [6:0]       amin,
  output logic [5:0]       ahour,
  output logic [DAY_W-1:0] aday
);
  localparam int HI_W = DAY_W - 8;

  logic any_en;
  logic fields_ok;
  logic hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      amin  <= '0;
      ahour <= '0;
      aday  <= '0;
    end else begin
      if (wr_amin)  amin            <= wbyte[6:0];
      if (wr_ahour) ahour           <= wbyte[5:0];
      if (wr_adayl) aday[7:0]       <= wbyte;
      if (wr_adayh) aday[DAY_W-1:8] <= wbyte[HI_W-1:0];
    end
  end

  assign any_en    = en.min_en | en.hour_en | en.day_en;
  assign fields_ok = (!en.min_en  || new_min  == amin)  &&
                     (!en.hour_en || new_hour == ahour) &&
                     (!en.day_en  || new_day  == aday);
  assign hit       = eval && (new_sec == '0) && any_en && fields_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (hit) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R11: with no field enabled a clear flag stays clear
  a_r11_no_enable_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_en && !flag) |=> !flag);

  // R10: the flag can only rise on a cycle that applies a tick
  a_r10_set_only_on_update: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !eval) |=> !flag);

  // R12: without a clear request the flag is sticky
  a_r12_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/rtc_core.sv
module rtc_core
  import rtc_core_pkg::*;
#(
  parameter int DAY_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1hz,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_write,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       rsp_valid,
  output logic [7:0] rsp_rdata,
  output logic       cal_busy,
  output logic       alarm_irq
);
  localparam int HI_W = DAY_W - 8;

  logic             tick_q;
  logic             run_en;
  logic             irq_en;
  match_en_t        en;
  logic             wr_acc;
  logic             rd_acc;
  logic             time_wr;
  logic             ctl_wr;
  logic             flag;
  logic [6:0]       sec_val,  sec_nxt,  min_val, min_nxt;
  logic [5:0]       hour_val, hour_nxt;
  logic [DAY_W-1:0] day_val,  day_nxt;
  logic             sec_top,  min_top,  hour_top;
  logic [6:0]       amin;
  logic [5:0]       ahour;
  logic [DAY_W-1:0] aday;
  logic [7:0]       rmux;
  logic [7:0]       day_hi_b, aday_hi_b;

  assign req_ready = 1'b1;
  assign wr_acc    = req_valid &  req_write;
  assign rd_acc    = req_valid & ~req_write;
  assign time_wr   = wr_acc & ~tick_q;
  assign ctl_wr    = wr_acc & (req_addr == ADDR_CTL);
  assign cal_busy  = tick_q;
  assign alarm_irq = flag & irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick_1hz & run_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_en <= 1'b0;
      irq_en <= 1'b0;
      en     <= '0;
    end else if (ctl_wr) begin
      run_en     <= req_wdata[CB_RUN];
      irq_en     <= req_wdata[CB_IEN];
      en.min_en  <= req_wdata[CB_MINEN];
      en.hour_en <= req_wdata[CB_HREN];
      en.day_en  <= req_wdata[CB_DAYEN];
    end
  end

  rtc_bcd_counter #(.TENS_W(3), .MAX_BCD(7'h59)) u_sec (
    .clk(clk), .rst_n(rst_n), .step(tick_q),
    .load(time_wr && req_addr == ADDR_SEC), .load_val(req_wdata[6:0]),
    .value(sec_val), .nxt(sec_nxt), .at_max(sec_top));

  rtc_bcd_counter #(.TENS_W(3), .MAX_BCD(7'h59)) u_min (
    .clk(clk), .rst_n(rst_n), .step(tick_q & sec_top),
    .load(time_wr && req_addr == ADDR_MIN), .load_val(req_wdata[6:0]),
    .value(min_val), .nxt(min_nxt), .at_max(min_top));

  rtc_bcd_counter #(.TENS_W(2), .MAX_BCD(6'h23)) u_hour (
    .clk(clk), .rst_n(rst_n), .step(tick_q & sec_top & min_top),
    .load(time_wr && req_addr == ADDR_HOUR), .load_val(req_wdata[5:0]),
    .value(hour_val), .nxt(hour_nxt), .at_max(hour_top));

  rtc_day_counter #(.DAY_W(DAY_W)) u_day (
    .clk(clk), .rst_n(rst_n), .step(tick_q & sec_top & min_top & hour_top),
    .ld_lo(time_wr && req_addr == ADDR_DAYL),
    .ld_hi(time_wr && req_addr == ADDR_DAYH),
    .wbyte(req_wdata), .value(day_val), .nxt(day_nxt));

  rtc_alarm_unit #(.DAY_W(DAY_W)) u_alarm (
    .clk(clk), .rst_n(rst_n),
    .wr_amin (wr_acc && req_addr == ADDR_AMIN),
    .wr_ahour(wr_acc && req_addr == ADDR_AHOUR),
    .wr_adayl(wr_acc && req_addr == ADDR_ADAYL),
    .wr_adayh(wr_acc && req_addr == ADDR_ADAYH),
    .wbyte(req_wdata), .en(en), .eval(tick_q),
    .new_sec(sec_nxt), .new_min(min_nxt), .new_hour(hour_nxt), .new_day(day_nxt),
    .clr(ctl_wr & req_wdata[CB_FLAG]), .flag(flag),
    .amin(amin), .ahour(ahour), .aday(aday));

  always_comb begin
    day_hi_b  = '0;
    aday_hi_b = '0;
    day_hi_b[HI_W-1:0]  = day_val[DAY_W-1:8];
    aday_hi_b[HI_W-1:0] = aday[DAY_W-1:8];
  end

  always_comb begin
    rmux = '0;
    unique case (req_addr)
      ADDR_CTL:   begin
        rmux[CB_BUSY]  = tick_q;
        rmux[CB_DAYEN] = en.day_en;
        rmux[CB_HREN]  = en.hour_en;
        rmux[CB_MINEN] = en.min_en;
        rmux[CB_FLAG]  = flag;
        rmux[CB_IEN]   = irq_en;
        rmux[CB_RUN]   = run_en;
      end
      ADDR_SEC:   rmux = {1'b0, sec_val};
      ADDR_MIN:   rmux = {1'b0, min_val};
      ADDR_HOUR:  rmux = {2'b0, hour_val};
      ADDR_DAYL:  rmux = day_val[7:0];
      ADDR_DAYH:  rmux = day_hi_b;
      ADDR_AMIN:  rmux = {1'b0, amin};
      ADDR_AHOUR: rmux = {2'b0, ahour};
      ADDR_ADAYL: rmux = aday[7:0];
      ADDR_ADAYH: rmux = aday_hi_b;
      default:    rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_acc;
      if (rd_acc) rsp_rdata <= rmux;
    end
  end

  // R2: a response appears only one cycle after an accepted read
  a_r2_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

  // R8: a tick taken while running makes the next cycle busy
  a_r8_busy_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && run_en) |=> cal_busy);

  // R9: a seconds write during busy loses to the tick update
  a_r9_busy_drops_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_busy && req_valid && req_write && req_addr == ADDR_SEC)
      |=> (sec_val == $past(sec_nxt)));

  // R7: without the run bit the seconds field holds unless written
  a_r7_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_busy && !(req_valid && req_write)) |=> $stable(sec_val));
endmodule

// File: tb/rtc_core_bench.sv
module rtc_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic [7:0] rsp_rdata;
  logic       cal_busy;
  logic       alarm_irq;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  always #5 clk = ~clk;

  rtc_core u_rtc_core (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cal_busy(cal_busy), .alarm_irq(alarm_irq));

  // {sec, min, hour, day16, exp_sec, exp_min, exp_hour, exp_day16}
  localparam logic [79:0] VEC [7] = '{
    {8'h00, 8'h00, 8'h00, 16'h0000, 8'h01, 8'h00, 8'h00, 16'h0000},
    {8'h09, 8'h30, 8'h05, 16'h0010, 8'h10, 8'h30, 8'h05, 16'h0010},
    {8'h59, 8'h12, 8'h07, 16'h0002, 8'h00, 8'h13, 8'h07, 16'h0002},
    {8'h59, 8'h59, 8'h09, 16'h0040, 8'h00, 8'h00, 8'h10, 16'h0040},
    {8'h59, 8'h59, 8'h23, 16'h0123, 8'h00, 8'h00, 8'h00, 16'h0124},
    {8'h59, 8'h59, 8'h23, 16'h7FFF, 8'h00, 8'h00, 8'h00, 16'h0000},
    {8'h59, 8'h59, 8'h19, 16'h00FF, 8'h00, 8'h00, 8'h20, 16'h00FF}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_rdata : 8'hXX;
  endtask

  task automatic tick_once();
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] s, input logic [7:0] m,
                          input logic [7:0] h, input logic [15:0] d);
    wr(8'h15, s); wr(8'h16, m); wr(8'h17, h);
    wr(8'h18, d[7:0]); wr(8'h19, d[15:8]);
  endtask

  task automatic set_alarm(input logic [7:0] m, input logic [7:0] h, input logic [15:0] d);
    wr(8'h1A, m); wr(8'h1B, h); wr(8'h1C, d[7:0]); wr(8'h1D, d[15:8]);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    rd(8'h14, r); chk("R1 ctl", r, 8'h00);
    rd(8'h15, r); chk("R1 sec", r, 8'h00);
    rd(8'h1D, r); chk("R1 alarm day hi", r, 8'h00);
    chk("R1 irq", {7'b0, alarm_irq}, 8'h00);
    chk("R1 busy", {7'b0, cal_busy}, 8'h00);

    // R3 R4 R5 R6 R2: vector table, one tick each
    for (int i = 0; i < 7; i++) begin
      logic [79:0] v;
      v = VEC[i];
      wr(8'h14, 8'h00);
      set_time(v[79:72], v[71:64], v[63:56], v[55:40]);
      wr(8'h14, 8'h01);
      tick_once();
      rd(8'h15, r); chk("R3 seconds", r, v[39:32]);
      rd(8'h16, r); chk("R4 minutes", r, v[31:24]);
      rd(8'h17, r); chk("R5 hours", r, v[23:16]);
      rd(8'h18, r); chk("R6 day low", r, v[7:0]);
      rd(8'h19, r); chk("R6 day high", r, v[15:8]);
    end

    // R7: tick while stopped is ignored
    wr(8'h14, 8'h00);
    set_time(8'h42, 8'h10, 8'h03, 16'h0001);
    tick_once();
    rd(8'h15, r); chk("R7 stopped seconds", r, 8'h42);
    chk("R7 stopped busy", {7'b0, cal_busy}, 8'h00);

    // R8: busy for one cycle, visible on pin and control bit 7
    wr(8'h14, 8'h01);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
    chk("R8 busy pin high", {7'b0, cal_busy}, 8'h01);
    rd(8'h14, r); chk("R8 busy bit in ctl", r, 8'h81);
    chk("R8 busy pin low after", {7'b0, cal_busy}, 8'h00);
    rd(8'h15, r); chk("R8 seconds updated", r, 8'h43);

    // R9: seconds write during busy is dropped
    wr(8'h15, 8'h05);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
    wr(8'h15, 8'h30);
    rd(8'h15, r); chk("R9 write dropped in busy", r, 8'h06);
    wr(8'h15, 8'h30);
    rd(8'h15, r); chk("R9 write outside busy", r, 8'h30);

    // R10 R13: full match sets flag, irq follows
    wr(8'h14, 8'h00);
    set_time(8'h59, 8'h44, 8'h10, 16'h0005);
    set_alarm(8'h45, 8'h10, 16'h0005);
    wr(8'h14, 8'h3B);
    tick_once();
    rd(8'h14, r); chk("R10 flag set on match", r, 8'h3F);
    chk("R13 irq with enable", {7'b0, alarm_irq}, 8'h01);
    rd(8'h1A, r); chk("R2 alarm minute readback", r, 8'h45);

    // R12: write 0 to flag bit keeps it
    wr(8'h14, 8'h3B);
    rd(8'h14, r); chk("R12 flag kept", r, 8'h3F);
    // R13: interrupt enable off masks irq
    wr(8'h14, 8'h39);
    chk("R13 irq masked", {7'b0, alarm_irq}, 8'h00);
    // R12: write 1 clears, bit 7 not writable
    wr(8'h14, 8'hBD);
    rd(8'h14, r); chk("R12 flag cleared", r, 8'h39);

    // R10: enabled day mismatches, no flag
    wr(8'h14, 8'h00);
    set_time(8'h59, 8'h44, 8'h10, 16'h0006);
    wr(8'h14, 8'h3B);
    tick_once();
    rd(8'h14, r); chk("R10 day mismatch", r, 8'h3B);
    chk("R13 irq low no flag", {7'b0, alarm_irq}, 8'h00);

    // R10: only minute enabled, hour mismatch ignored
    wr(8'h14, 8'h00);
    set_time(8'h59, 8'h44, 8'h10, 16'h0006);
    wr(8'h1B, 8'h11);
    wr(8'h14, 8'h0B);
    tick_once();
    rd(8'h14, r); chk("R10 minute only match", r, 8'h0F);
    wr(8'h14, 8'h0F);
    rd(8'h14, r); chk("R12 clear again", r, 8'h0B);

    // R11: no enables, all fields equal
    wr(8'h14, 8'h00);
    set_time(8'h59, 8'h44, 8'h10, 16'h0005);
    set_alarm(8'h45, 8'h10, 16'h0005);
    wr(8'h14, 8'h03);
    tick_once();
    rd(8'h14, r); chk("R11 no enable no flag", r, 8'h03);

    // R11: match while seconds not reaching 00
    wr(8'h14, 8'h00);
    set_time(8'h30, 8'h45, 8'h10, 16'h0005);
    wr(8'h14, 8'h0B);
    tick_once();
    rd(8'h14, r); chk("R11 no flag off rollover", r, 8'h0B);
    rd(8'h15, r); chk("R3 seconds 31", r, 8'h31);

    finish_run();
  end
endmodule